// File: doc/BRIEF.md
# Shared Timer Clock Prescaler

This block produces the count-enable strobes for two timer/counters. Both timers draw on one free-running prescaler counter, which yields enables at the system clock divided by 1, 8, 64, 256 and 1024. As an alternative, either timer can count edges seen on its own external pin. The pin passes through a two-stage synchronizer and an edge detector before it reaches the timer, and the prescaler never divides it.

The block also holds a one-byte control register on a small register port. Its only live bit is a prescaler reset that clears itself. Writing that bit restarts the shared counter, which realigns the divided enables of both timers in the same cycle. Each timer selects its clock source with a 3-bit code. The block drives a single-cycle enable pulse per timer from a register, so the timers downstream see glitch-free strobes.

Top module: `tmr_clk_prescaler`

## Requirements
- R1: After reset, the control register reads 0x00 and both count enables are low while their select codes are 000.
- R2: A register write to address 0x23 with data 0x01 sets the prescaler-reset bit (bit 0). The bit reads as 1 for the single cycle after the write edge and as 0 from the next cycle on, unless it is written again.
- R3: Bits 7..1 of the control register always read as zero. Writing them has no effect. A write to any other address does not touch the register or the prescaler, and the read data is 0x00 at any other address.
- R4: Select codes 001, 010, 011, 100 and 101 give one-cycle enables at the system clock divided by 1, 8, 64, 256 and 1024. For divide-by-N with N>1, take the edge that writes the prescaler reset as edge 0. The first enable is then high during the cycle after edge N+1, and further enables follow every N cycles. Divide-by-1 is high in every cycle.
- R5: Select code 000 keeps a timer's enable low.
- R6: Select code 111 gives exactly one enable pulse per rising edge on the timer's pin. Select code 110 gives exactly one pulse per falling edge. The pulse is high during the cycle after the third clock edge that sees the new pin level, and a rise and a fall never pulse together.
- R7: Pin-clocked enables are not divided by the prescaler, and writing the prescaler reset does not disturb them.
- R8: One prescaler reset restarts the divided enables of both timers from the same edge. The prescaler counter is zero in the cycle after the reset bit is seen.
- R9: Switching a timer onto or off an edge-select code while its pin is held steady produces no enable pulse.
- R10: Edge counting is exact for a pin whose half periods are each a little longer than one system clock (frequency just under half the clock), and also at one quarter of the clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | AW (6) | Register address; the control register sits at 0x23 |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data for the addressed register |
| ext_pin | input | N_TMR (2) | External clock pins, one per timer |
| csel | input | 3*N_TMR (6) | Clock-select codes, timer t in bits [3t+2:3t] |
| cnt_en | output | N_TMR (2) | Registered one-cycle count enables, one per timer |

## Verification
A prescaler reset can land in the same cycle as a divided enable that is already due, and also while a pin-edge pulse is in flight through the synchronizer. The bench writes the reset bit while both timers run on divided taps, and again while both pins toggle near half the clock rate. A scoreboard of expected enable cycles, counted from the write edge, judges the divided case: no stale pulse may appear and every new pulse must fall exactly on its slot. In the pin case, the pulse counts must still equal the number of edges that were driven.

// File: rtl/tcp_pkg.sv
package tcp_pkg;

  localparam int SEL_W  = 3;
  localparam int N_TAPS = 5;

  typedef enum logic [SEL_W-1:0] {
    SRC_OFF      = 3'd0,
    SRC_DIV1     = 3'd1,
    SRC_DIV8     = 3'd2,
    SRC_DIV64    = 3'd3,
    SRC_DIV256   = 3'd4,
    SRC_DIV1024  = 3'd5,
    SRC_PIN_FALL = 3'd6,
    SRC_PIN_RISE = 3'd7
  } clk_src_e;

  // log2 of the division ratio for tap index 0..N_TAPS-1
  function automatic int tap_shift(input int idx);
    case (idx)
      0:       return 0;
      1:       return 3;
      2:       return 6;
      3:       return 8;
      default: return 10;
    endcase
  endfunction

  // a tap is due when the low 'sh' bits of the counter are all ones
  function automatic logic tap_due(input logic [31:0] cnt, input int sh);
    logic [31:0] mask;
    mask = (32'd1 << sh) - 32'd1;
    return (cnt & mask) == mask;
  endfunction

endpackage

// File: rtl/tcp_ctrl_reg.sv
module tcp_ctrl_reg #(
  parameter int AW        = 6,
  parameter int CTRL_ADDR = 'h23
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [AW-1:0] reg_addr,
  input  logic [7:0]    reg_wdata,
  output logic [7:0]    reg_rdata,
  output logic          psr_bit
);

  localparam logic [7:0] LIVE_MASK = 8'h01;

  logic       addr_hit;
  logic [7:0] wr_val;
  logic       psr_set;

  assign addr_hit = (reg_addr == AW'(CTRL_ADDR));
  assign wr_val   = reg_wdata & LIVE_MASK;
  assign psr_set  = reg_wr && addr_hit && (wr_val == LIVE_MASK);

  // self-clearing: holds for one cycle unless written again
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) psr_bit <= 1'b0;
    else        psr_bit <= psr_set;
  end

  assign reg_rdata = addr_hit ? {7'd0, psr_bit} : 8'h00;

endmodule

// File: rtl/tcp_prescaler.sv
module tcp_prescaler import tcp_pkg::*; #(
  parameter int PS_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  output logic [PS_W-1:0]   cnt,
  output logic [N_TAPS-1:0] tap_hit
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else          cnt <= cnt + 1'b1;
  end

  // divided taps are masked while a restart is pending so no stale pulse leaks
  for (genvar i = 0; i < N_TAPS; i++) begin : g_tap
    if (tap_shift(i) == 0) begin : g_full
      assign tap_hit[i] = 1'b1;
    end else begin : g_div
      assign tap_hit[i] = !clr && tap_due(32'(cnt), tap_shift(i));
    end
  end

endmodule

// File: rtl/tcp_pin_edge.sv
module tcp_pin_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic rise,
  output logic fall
);

  logic sync1, sync2, prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= 1'b0;
      sync2 <= 1'b0;
      prev  <= 1'b0;
    end else begin
      sync1 <= pin;
      sync2 <= sync1;
      prev  <= sync2;
    end
  end

  assign rise = sync2 & ~prev;
  assign fall = ~sync2 & prev;

endmodule

// File: rtl/tcp_src_mux.sv
module tcp_src_mux import tcp_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SEL_W-1:0]  sel,
  input  logic [N_TAPS-1:0] tap_hit,
  input  logic              rise,
  input  logic              fall,
  output logic              en
);

  logic en_d;

  always_comb begin
    case (clk_src_e'(sel))
      SRC_DIV1:     en_d = tap_hit[0];
      SRC_DIV8:     en_d = tap_hit[1];
      SRC_DIV64:    en_d = tap_hit[2];
      SRC_DIV256:   en_d = tap_hit[3];
      SRC_DIV1024:  en_d = tap_hit[4];
      SRC_PIN_FALL: en_d = fall;
      SRC_PIN_RISE: en_d = rise;
      default:      en_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en <= 1'b0;
    else        en <= en_d;
  end

endmodule

// File: rtl/tmr_clk_prescaler.sv
module tmr_clk_prescaler import tcp_pkg::*; #(
  parameter int N_TMR     = 2,
  parameter int PS_W      = 10,
  parameter int AW        = 6,
  parameter int CTRL_ADDR = 'h23
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   reg_wr,
  input  logic [AW-1:0]          reg_addr,
  input  logic [7:0]             reg_wdata,
  output logic [7:0]             reg_rdata,
  input  logic [N_TMR-1:0]       ext_pin,
  input  logic [N_TMR*SEL_W-1:0] csel,
  output logic [N_TMR-1:0]       cnt_en
);

  // named internal events, brought out for the checker
  logic              psr_bit;
  logic [PS_W-1:0]   pre_cnt;
  logic [N_TAPS-1:0] tap_hit;
  logic [N_TMR-1:0]  pin_rise;
  logic [N_TMR-1:0]  pin_fall;

  tcp_ctrl_reg #(.AW(AW), .CTRL_ADDR(CTRL_ADDR)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .psr_bit   (psr_bit)
  );

  // PS_W must cover the widest tap shift
  tcp_prescaler #(.PS_W(PS_W)) u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (psr_bit),
    .cnt     (pre_cnt),
    .tap_hit (tap_hit)
  );

  for (genvar t = 0; t < N_TMR; t++) begin : g_tmr
    tcp_pin_edge u_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .pin   (ext_pin[t]),
      .rise  (pin_rise[t]),
      .fall  (pin_fall[t])
    );

    tcp_src_mux u_mux (
      .clk     (clk),
      .rst_n   (rst_n),
      .sel     (csel[t*SEL_W +: SEL_W]),
      .tap_hit (tap_hit),
      .rise    (pin_rise[t]),
      .fall    (pin_fall[t]),
      .en      (cnt_en[t])
    );
  end

endmodule

// File: rtl/tcp_checker.sv
module tcp_checker import tcp_pkg::*; #(
  parameter int N_TMR     = 2,
  parameter int PS_W      = 10,
  parameter int AW        = 6,
  parameter int CTRL_ADDR = 'h23
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   reg_wr,
  input logic [AW-1:0]          reg_addr,
  input logic                   wbit0,
  input logic [7:0]             reg_rdata,
  input logic [N_TMR*SEL_W-1:0] csel,
  input logic [N_TMR-1:0]       cnt_en,
  input logic                   psr_bit,
  input logic [PS_W-1:0]        pre_cnt,
  input logic [N_TMR-1:0]       pin_rise,
  input logic [N_TMR-1:0]       pin_fall
);

  logic rewrite;
  assign rewrite = reg_wr && wbit0 && (reg_addr == AW'(CTRL_ADDR));

  p_psr_selfclear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (psr_bit && !rewrite) |=> !psr_bit);

  p_rsvd_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[7:1] == 7'd0);

  p_psr_realign_r8: assert property (@(posedge clk) disable iff (!rst_n)
    psr_bit |=> (pre_cnt == '0));

  for (genvar t = 0; t < N_TMR; t++) begin : g_chk
    p_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (csel[t*SEL_W +: SEL_W] == 3'd0) |=> !cnt_en[t]);

    p_div1_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (csel[t*SEL_W +: SEL_W] == 3'd1) |=> cnt_en[t]);

    p_edge_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
      pin_rise[t] |=> !pin_rise[t]);

    p_edge_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(pin_rise[t] && pin_fall[t]));
  end

endmodule

bind tmr_clk_prescaler tcp_checker #(
  .N_TMR(N_TMR), .PS_W(PS_W), .AW(AW), .CTRL_ADDR(CTRL_ADDR)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .wbit0     (reg_wdata[0]),
  .reg_rdata (reg_rdata),
  .csel      (csel),
  .cnt_en    (cnt_en),
  .psr_bit   (psr_bit),
  .pre_cnt   (pre_cnt),
  .pin_rise  (pin_rise),
  .pin_fall  (pin_fall)
);

// File: tb/tb_tmr_clk_prescaler.sv
module tb_tmr_clk_prescaler;

  localparam int CLK_PERIOD = 20;
  localparam int CTRL       = 'h23;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic [5:0] reg_addr = 6'(CTRL);
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic [1:0] ext_pin = 2'b00;
  logic [5:0] csel = 6'd0;
  logic [1:0] cnt_en;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  int q0[$];
  int q1[$];
  bit mon_on = 0;
  bit cnt_on = 0;
  int pulses0 = 0, pulses1 = 0;

  tmr_clk_prescaler dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ext_pin(ext_pin),
    .csel(csel), .cnt_en(cnt_en)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // expected cycle of each divided pulse relative to the write edge
  task automatic push_div(input int t, input int c0, input int n, input int cnt);
    for (int k = 0; k < cnt; k++) begin
      if (t == 0) q0.push_back(c0 + n + 1 + k*n);
      else        q1.push_back(c0 + n + 1 + k*n);
    end
  endtask

  // scoreboard monitor for divided enables
  always @(negedge clk) begin
    if (mon_on) begin
      while (q0.size() > 0 && q0[0] < cyc) begin
        check(0, "R4 missed pulse t0", cyc, q0[0]);
        void'(q0.pop_front());
      end
      while (q1.size() > 0 && q1[0] < cyc) begin
        check(0, "R8 missed pulse t1", cyc, q1[0]);
        void'(q1.pop_front());
      end
      if (cnt_en[0]) begin
        if (q0.size() > 0 && q0[0] == cyc) begin
          check(1, "R4", cyc, cyc);
          void'(q0.pop_front());
        end else check(0, "R4 unexpected pulse t0", cyc, (q0.size() > 0) ? q0[0] : -1);
      end
      if (cnt_en[1]) begin
        if (q1.size() > 0 && q1[0] == cyc) begin
          check(1, "R8", cyc, cyc);
          void'(q1.pop_front());
        end else check(0, "R8 unexpected pulse t1", cyc, (q1.size() > 0) ? q1[0] : -1);
      end
    end
    if (cnt_on) begin
      if (cnt_en[0]) pulses0++;
      if (cnt_en[1]) pulses1++;
    end
  end

  // write on one edge; returns at the negedge after the write edge
  task automatic wr_reg(input logic [5:0] a, input logic [7:0] d, output int c0);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = 6'(CTRL);
    c0 = cyc;
  endtask

  task automatic wait_until(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic toggle_pins(input int half, input int n_per);
    #1;
    for (int i = 0; i < 2*n_per; i++) begin
      #(half);
      ext_pin = ~ext_pin;
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    int c0, c1, dummy;
    bit all_hi;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(reg_rdata == 8'h00, "R1 rdata", reg_rdata, 0);
    check(cnt_en == 2'b00, "R1 cnt_en", cnt_en, 0);

    // R4 / R8: div8 on timer 0, div64 on timer 1, restart together
    csel = {3'd3, 3'd2};
    repeat (4) @(negedge clk);
    wr_reg(6'(CTRL), 8'h01, c0);
    check(reg_rdata == 8'h01, "R2 bit set one cycle", reg_rdata, 1);
    push_div(0, c0, 8, 20);
    push_div(1, c0, 64, 2);
    @(negedge clk);
    check(reg_rdata == 8'h00, "R2 self-clear", reg_rdata, 0);
    mon_on = 1;
    wait_until(c0 + 40);
    // R3: reserved bits ignored, prescaler not restarted
    wr_reg(6'(CTRL), 8'hFE, dummy);
    check(reg_rdata == 8'h00, "R3 reserved write", reg_rdata, 0);
    @(negedge clk);
    check(reg_rdata == 8'h00, "R3 reserved write later", reg_rdata, 0);
    // R3: other address ignored
    wr_reg(6'(CTRL + 1), 8'h01, dummy);
    reg_addr = 6'(CTRL + 1);
    check(reg_rdata == 8'h00, "R3 other address rdata", reg_rdata, 0);
    reg_addr = 6'(CTRL);
    @(negedge clk);
    check(reg_rdata == 8'h00, "R3 register untouched", reg_rdata, 0);
    wait_until(c0 + 165);
    mon_on = 0;
    check(q0.size() == 0, "R4 queue drained t0", q0.size(), 0);
    check(q1.size() == 0, "R8 queue drained t1", q1.size(), 0);

    // R4: divide by 1 high every cycle
    csel = {3'd5, 3'd1};
    repeat (2) @(negedge clk);
    all_hi = 1;
    for (int i = 0; i < 6; i++) begin
      if (!cnt_en[0]) all_hi = 0;
      @(negedge clk);
    end
    check(all_hi, "R4 div1 every cycle", all_hi, 1);

    // R4: divide by 1024 first pulse
    wr_reg(6'(CTRL), 8'h01, c1);
    wait_until(c1 + 1024);
    check(cnt_en[1] == 1'b0, "R4 div1024 not early", cnt_en[1], 0);
    @(negedge clk);
    check(cnt_en[1] == 1'b1, "R4 div1024 first pulse", cnt_en[1], 1);

    // R5: stopped timers stay idle
    csel = 6'd0;
    @(negedge clk);
    pulses0 = 0; pulses1 = 0; cnt_on = 1;
    repeat (40) @(negedge clk);
    cnt_on = 0;
    check(pulses0 + pulses1 == 0, "R5 stopped", pulses0 + pulses1, 0);

    // R9: switching onto/off edge select with steady pins
    ext_pin = 2'b11;
    repeat (6) @(negedge clk);
    pulses0 = 0; pulses1 = 0; cnt_on = 1;
    csel = {3'd6, 3'd7};
    repeat (8) @(negedge clk);
    csel = 6'd0;
    repeat (4) @(negedge clk);
    ext_pin = 2'b00;
    repeat (6) @(negedge clk);
    csel = {3'd6, 3'd7};
    repeat (8) @(negedge clk);
    cnt_on = 0;
    check(pulses0 + pulses1 == 0, "R9 no pulse on select switch", pulses0 + pulses1, 0);

    // R10 / R6 / R7: just under half the clock, with a prescaler reset mid-run
    pulses0 = 0; pulses1 = 0; cnt_on = 1;
    fork
      toggle_pins(22, 60);
      begin
        repeat (30) @(negedge clk);
        wr_reg(6'(CTRL), 8'h01, dummy);
      end
    join
    repeat (6) @(negedge clk);
    cnt_on = 0;
    check(pulses0 == 60, "R10 rise count near half rate", pulses0, 60);
    check(pulses1 == 60, "R7 fall count with prescaler reset", pulses1, 60);

    // R6 / R10: one quarter of the clock
    pulses0 = 0; pulses1 = 0; cnt_on = 1;
    toggle_pins(40, 25);
    repeat (6) @(negedge clk);
    cnt_on = 0;
    check(pulses0 == 25, "R6 rise count quarter rate", pulses0, 25);
    check(pulses1 == 25, "R6 fall count quarter rate", pulses1, 25);

    // R6: latency from a pin edge, sampled at the third edge
    @(negedge clk);
    ext_pin[0] = ~ext_pin[0];
    c1 = cyc;
    wait_until(c1 + 2);
    check(cnt_en[0] == 1'b0, "R6 not before third edge", cnt_en[0], 0);
    @(negedge clk);
    check(cnt_en[0] == ext_pin[0], "R6 pulse after third edge", cnt_en[0], ext_pin[0]);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule